// File: doc/BRIEF.md
# Banked UART Host Register Decoder

This block is the host-facing register front end of a UART channel. A processor drives a 3-bit address, separate read and write strobes and an 8-bit write bus; the block turns each access into a register update, a read-data value, or a strobe towards the transmit or receive FIFO. Only eight addresses exist, so the register space is folded into three banks that overlap on the same addresses. The value currently held in the line control register picks the bank.

With the top bit of the line control register clear, the general bank is visible. It holds the data port, interrupt enable, interrupt status / FIFO control, line control, modem control, line status, modem status and scratch registers. With that bit set, addresses 0 and 1 reach the two bytes of the baud divisor. When the whole line control register equals a key value (0xBF by default), an enhanced bank also opens. It holds an enhanced-feature byte and four flow-control character bytes, while the divisor stays at addresses 0 and 1. Status bytes are supplied by neighbouring logic through inputs. Every configuration byte is driven out as a port for the serial, baud and flow-control logic.

Top module: `uart_regbank_decoder`

## Requirements
- R1: Out of reset, every writable register reads as 0x00 except the 16-bit divisor, which is 0x0001; tx_push and rx_pop are low, and rdata is 0x00 whenever rd_en is low.
- R2: The bank is the general bank when lcr[7]=0, the enhanced bank when lcr equals 0xBF, and the divisor bank when lcr[7]=1 and lcr differs from 0xBF.
- R3: In the general bank, address 1 is interrupt enable, 4 is modem control and 7 is scratch; each reads back what was written. A write to address 2 loads the FIFO control byte, and a read of address 2 returns isr_in.
- R4: A read of address 0 in the general bank returns rx_data in the same cycle and raises rx_pop for exactly one cycle, in the cycle after the read; no other read raises rx_pop.
- R5: A write to address 0 in the general bank raises tx_push for exactly one cycle, in the cycle after the write, with tx_data holding the written byte.
- R6: In the general bank, reads of addresses 5 and 6 return lsr_in and msr_in; writes to those addresses change no register and raise no strobe.
- R7: In the divisor and enhanced banks, address 0 reads and writes divisor[7:0] and address 1 divisor[15:8]; these accesses raise neither tx_push nor rx_pop.
- R8: In the enhanced bank, address 2 is the enhanced-feature byte and addresses 4, 5, 6, 7 are xon1, xon2, xoff1, xoff2, each readable and writable.
- R9: Address 3 reads and writes the line control register in every bank.
- R10: In the divisor bank, addresses 2, 4, 5, 6 and 7 are unmapped: reads return 0x00 and raise no strobe, and writes change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| isr_in | input | 8 | Interrupt status byte |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| tx_push | output | 1 | One-cycle push into the transmit FIFO |
| tx_data | output | 8 | Byte being pushed |
| rx_pop | output | 1 | One-cycle pop of the receive FIFO |
| lcr | output | 8 | Line control register |
| ier | output | 8 | Interrupt enable register |
| fcr | output | 8 | FIFO control register |
| mcr | output | 8 | Modem control register |
| efr | output | 8 | Enhanced feature register |
| xon1 | output | 8 | First XON character |
| xon2 | output | 8 | Second XON character |
| xoff1 | output | 8 | First XOFF character |
| xoff2 | output | 8 | Second XOFF character |
| divisor | output | 16 | Baud divisor |

## Verification
The bench drives the line control register through 0x00, 0x80 and 0xBF and probes the same address in each bank. A decoder that tested only bit 7 would let the enhanced registers leak into the divisor bank, and one that tested only the key would hide the divisor once the key was set. Writes to the status addresses and to the unmapped divisor-bank addresses are followed by readback of every register they could have hit, so that a slip into a neighbouring register shows up. The FIFO strobes are sampled in the cycle after the access and again one cycle later. Data-port accesses made while the divisor bank is open must produce no strobe, which exposes a design that decodes address 0 without the bank.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 3;
    localparam int unsigned NXCH = 4;

    typedef enum logic [1:0] {
        BANK_GEN,
        BANK_DIV,
        BANK_ENH
    } bank_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_HOLD,
        SEL_IER,
        SEL_ISR_FCR,
        SEL_LCR,
        SEL_MCR,
        SEL_LSR,
        SEL_MSR,
        SEL_SPR,
        SEL_DLL,
        SEL_DLM,
        SEL_EFR,
        SEL_XON1,
        SEL_XON2,
        SEL_XOFF1,
        SEL_XOFF2
    } sel_e;

    typedef struct packed {
        logic [DW-1:0]           lcr;
        logic [DW-1:0]           ier;
        logic [DW-1:0]           fcr;
        logic [DW-1:0]           mcr;
        logic [DW-1:0]           spr;
        logic [DW-1:0]           efr;
        logic [NXCH-1:0][DW-1:0] xch;
        logic [2*DW-1:0]         div;
        logic [DW-1:0]           thr;
        logic                    push;
        logic                    pop;
    } regs_t;

endpackage

// File: rtl/regbank_select.sv
module regbank_select
    import uart_regbank_pkg::*;
#(
    parameter logic [DW-1:0] ENH_KEY = 8'hBF
) (
    input  logic [DW-1:0] lcr_q,
    output bank_e         bank
);
    always_comb begin
        if (lcr_q == ENH_KEY)  bank = BANK_ENH;
        else if (lcr_q[DW-1])  bank = BANK_DIV;
        else                   bank = BANK_GEN;
    end
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
    import uart_regbank_pkg::*;
(
    input  bank_e         bank,
    input  logic [AW-1:0] addr,
    output sel_e          sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr == 3'd3) begin
            sel = SEL_LCR;
        end else begin
            unique case (bank)
                BANK_GEN: begin
                    case (addr)
                        3'd0:    sel = SEL_HOLD;
                        3'd1:    sel = SEL_IER;
                        3'd2:    sel = SEL_ISR_FCR;
                        3'd4:    sel = SEL_MCR;
                        3'd5:    sel = SEL_LSR;
                        3'd6:    sel = SEL_MSR;
                        3'd7:    sel = SEL_SPR;
                        default: sel = SEL_NONE;
                    endcase
                end
                BANK_DIV: begin
                    case (addr)
                        3'd0:    sel = SEL_DLL;
                        3'd1:    sel = SEL_DLM;
                        default: sel = SEL_NONE;
                    endcase
                end
                BANK_ENH: begin
                    case (addr)
                        3'd0:    sel = SEL_DLL;
                        3'd1:    sel = SEL_DLM;
                        3'd2:    sel = SEL_EFR;
                        3'd4:    sel = SEL_XON1;
                        3'd5:    sel = SEL_XON2;
                        3'd6:    sel = SEL_XOFF1;
                        3'd7:    sel = SEL_XOFF2;
                        default: sel = SEL_NONE;
                    endcase
                end
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import uart_regbank_pkg::*;
#(
    parameter logic [2*DW-1:0] DIV_RESET = 16'h0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    output regs_t         regs_q
);
    regs_t regs_d;

    always_comb begin
        regs_d      = regs_q;
        regs_d.push = 1'b0;
        regs_d.pop  = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_HOLD: begin
                    regs_d.thr  = wdata;
                    regs_d.push = 1'b1;
                end
                SEL_IER:     regs_d.ier = wdata;
                SEL_ISR_FCR: regs_d.fcr = wdata;
                SEL_LCR:     regs_d.lcr = wdata;
                SEL_MCR:     regs_d.mcr = wdata;
                SEL_SPR:     regs_d.spr = wdata;
                SEL_DLL:     regs_d.div[DW-1:0] = wdata;
                SEL_DLM:     regs_d.div[2*DW-1:DW] = wdata;
                SEL_EFR:     regs_d.efr = wdata;
                SEL_XON1:    regs_d.xch[0] = wdata;
                SEL_XON2:    regs_d.xch[1] = wdata;
                SEL_XOFF1:   regs_d.xch[2] = wdata;
                SEL_XOFF2:   regs_d.xch[3] = wdata;
                default:     ;
            endcase
        end
        if (rd_en && sel == SEL_HOLD) regs_d.pop = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.div <= DIV_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Configuration state only, strobes left out.
    logic [$bits(regs_t)-3:0] cfg_q;
    assign cfg_q = regs_q[$bits(regs_t)-1:2];

    // R6: writes to the status addresses leave every register alone
    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_LSR || sel == SEL_MSR)) |=> $stable(cfg_q));

    // R10: writes to unmapped addresses leave every register alone
    a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(cfg_q) && !regs_q.push));

    // R4: only a data-port read may pop
    a_r4_no_stray_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || sel != SEL_HOLD) |=> !regs_q.pop);
endmodule

// File: rtl/regbank_readmux.sv
module regbank_readmux
    import uart_regbank_pkg::*;
(
    input  logic          rd_en,
    input  sel_e          sel,
    input  regs_t         regs_q,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] isr_in,
    input  logic [DW-1:0] lsr_in,
    input  logic [DW-1:0] msr_in,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mux;

    always_comb begin
        case (sel)
            SEL_HOLD:    mux = rx_data;
            SEL_IER:     mux = regs_q.ier;
            SEL_ISR_FCR: mux = isr_in;
            SEL_LCR:     mux = regs_q.lcr;
            SEL_MCR:     mux = regs_q.mcr;
            SEL_LSR:     mux = lsr_in;
            SEL_MSR:     mux = msr_in;
            SEL_SPR:     mux = regs_q.spr;
            SEL_DLL:     mux = regs_q.div[DW-1:0];
            SEL_DLM:     mux = regs_q.div[2*DW-1:DW];
            SEL_EFR:     mux = regs_q.efr;
            SEL_XON1:    mux = regs_q.xch[0];
            SEL_XON2:    mux = regs_q.xch[1];
            SEL_XOFF1:   mux = regs_q.xch[2];
            SEL_XOFF2:   mux = regs_q.xch[3];
            default:     mux = '0;
        endcase
        rdata = rd_en ? mux : '0;
    end
endmodule

// File: rtl/uart_regbank_decoder.sv
module uart_regbank_decoder
    import uart_regbank_pkg::*;
#(
    parameter logic [DW-1:0]   ENH_KEY   = 8'hBF,
    parameter logic [2*DW-1:0] DIV_RESET = 16'h0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   rx_data,
    input  logic [DW-1:0]   isr_in,
    input  logic [DW-1:0]   lsr_in,
    input  logic [DW-1:0]   msr_in,
    output logic            tx_push,
    output logic [DW-1:0]   tx_data,
    output logic            rx_pop,
    output logic [DW-1:0]   lcr,
    output logic [DW-1:0]   ier,
    output logic [DW-1:0]   fcr,
    output logic [DW-1:0]   mcr,
    output logic [DW-1:0]   efr,
    output logic [DW-1:0]   xon1,
    output logic [DW-1:0]   xon2,
    output logic [DW-1:0]   xoff1,
    output logic [DW-1:0]   xoff2,
    output logic [2*DW-1:0] divisor
);
    bank_e bank;
    sel_e  sel;
    regs_t regs_q;

    regbank_select #(.ENH_KEY(ENH_KEY)) u_select (
        .lcr_q (regs_q.lcr),
        .bank  (bank)
    );

    regbank_decode u_decode (
        .bank (bank),
        .addr (addr),
        .sel  (sel)
    );

    regbank_store #(.DIV_RESET(DIV_RESET)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .sel    (sel),
        .wdata  (wdata),
        .regs_q (regs_q)
    );

    regbank_readmux u_readmux (
        .rd_en   (rd_en),
        .sel     (sel),
        .regs_q  (regs_q),
        .rx_data (rx_data),
        .isr_in  (isr_in),
        .lsr_in  (lsr_in),
        .msr_in  (msr_in),
        .rdata   (rdata)
    );

    assign tx_push = regs_q.push;
    assign tx_data = regs_q.thr;
    assign rx_pop  = regs_q.pop;
    assign lcr     = regs_q.lcr;
    assign ier     = regs_q.ier;
    assign fcr     = regs_q.fcr;
    assign mcr     = regs_q.mcr;
    assign efr     = regs_q.efr;
    assign xon1    = regs_q.xch[0];
    assign xon2    = regs_q.xch[1];
    assign xoff1   = regs_q.xch[2];
    assign xoff2   = regs_q.xch[3];
    assign divisor = regs_q.div;

    // R4: a pop follows a read of address 0 taken while lcr[7] was clear
    a_r4_pop_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> ($past(rd_en) && $past(addr) == 3'd0 && !$past(lcr[DW-1])));

    // R5: a push follows a write of address 0 and carries its byte
    a_r5_push_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> ($past(wr_en) && $past(addr) == 3'd0 && tx_data == $past(wdata)));

    // R5: single-cycle push when writes are not back to back
    a_r5_push_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !wr_en) |=> !tx_push);

    // R9: address 3 always lands in the line control register
    a_r9_lcr_any_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3) |=> (lcr == $past(wdata)));

    // R2: enhanced bytes move only while the key is loaded
    a_r2_enh_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr != ENH_KEY) |=> ($stable(efr) && $stable(xon1) && $stable(xoff2)));
endmodule

// File: tb/uart_regbank_decoder_test.sv
module uart_regbank_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  rx_data = 8'h6B;
    logic [7:0]  isr_in = 8'h81;
    logic [7:0]  lsr_in = 8'h60;
    logic [7:0]  msr_in = 8'hB0;
    logic        tx_push, rx_pop;
    logic [7:0]  tx_data, lcr, ier, fcr, mcr, efr, xon1, xon2, xoff1, xoff2;
    logic [15:0] divisor;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_regbank_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .isr_in(isr_in),
        .lsr_in(lsr_in), .msr_in(msr_in), .tx_push(tx_push), .tx_data(tx_data),
        .rx_pop(rx_pop), .lcr(lcr), .ier(ier), .fcr(fcr), .mcr(mcr), .efr(efr),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2), .divisor(divisor)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [7:0]  lcr_val;
        logic [2:0]  a;
        logic [7:0]  d;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{"R3", 8'h00, 3'd1, 8'hA5, 8'hA5},   // interrupt enable
        '{"R3", 8'h00, 3'd4, 8'h3C, 8'h3C},   // modem control
        '{"R3", 8'h00, 3'd7, 8'h5A, 8'h5A},   // scratch
        '{"R3", 8'h00, 3'd2, 8'hC1, 8'h81},   // FIFO control write, status read
        '{"R6", 8'h00, 3'd5, 8'hFF, 8'h60},   // line status
        '{"R6", 8'h00, 3'd6, 8'hFF, 8'hB0},   // modem status
        '{"R7", 8'h80, 3'd0, 8'h34, 8'h34},   // divisor low
        '{"R7", 8'h80, 3'd1, 8'h12, 8'h12},   // divisor high
        '{"R2", 8'h80, 3'd2, 8'hEE, 8'h00},   // no EFR without key
        '{"R8", 8'hBF, 3'd2, 8'h10, 8'h10},   // EFR
        '{"R8", 8'hBF, 3'd4, 8'h11, 8'h11},   // xon1
        '{"R8", 8'hBF, 3'd5, 8'h13, 8'h13},   // xon2
        '{"R8", 8'hBF, 3'd6, 8'h19, 8'h19},   // xoff1
        '{"R8", 8'hBF, 3'd7, 8'h93, 8'h93},   // xoff2
        '{"R7", 8'hBF, 3'd0, 8'h77, 8'h77}    // divisor low via enhanced bank
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 lcr", {8'h0, lcr}, 16'h0000);
        check("R1 ier", {8'h0, ier}, 16'h0000);
        check("R1 efr", {8'h0, efr}, 16'h0000);
        check("R1 divisor", divisor, 16'h0001);
        check("R1 strobes", {14'h0, tx_push, rx_pop}, 16'h0000);
        check("R1 rdata idle", {8'h0, rdata}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            wr(3'd3, VECS[i].lcr_val);
            wr(VECS[i].a, VECS[i].d);
            rd(VECS[i].a, r);
            check($sformatf("%s vector %0d", VECS[i].tag, i), {8'h0, r}, {8'h0, VECS[i].exp});
        end

        // R7 R8 outputs after the table
        check("R7 divisor", divisor, 16'h1277);
        check("R8 efr", {8'h0, efr}, 16'h0010);
        check("R8 xon/xoff", {xon1, xoff2}, 16'h1193);
        check("R8 xon2/xoff1", {xon2, xoff1}, 16'h1319);
        check("R3 fcr", {8'h0, fcr}, 16'h00C1);
        check("R3 ier/mcr", {ier, mcr}, 16'hA53C);

        // R9 line control reachable from the enhanced bank
        rd(3'd3, r);
        check("R9 read lcr in enhanced bank", {8'h0, r}, 16'h00BF);
        wr(3'd3, 8'h00);
        check("R9 lcr back to general", {8'h0, lcr}, 16'h0000);

        // R6 status writes ignored
        wr(3'd5, 8'hFF);
        check("R6 no push after status write", {15'h0, tx_push}, 16'h0000);
        wr(3'd6, 8'hFF);
        check("R6 regs intact", {ier, mcr}, 16'hA53C);
        check("R6 lcr/fcr intact", {lcr, fcr}, 16'h00C1);
        rd(3'd7, r);
        check("R6 scratch intact", {8'h0, r}, 16'h005A);

        // R4 receive pop
        rd(3'd0, r);
        check("R4 rx data", {8'h0, r}, 16'h006B);
        check("R4 pop high", {15'h0, rx_pop}, 16'h0001);
        @(negedge clk);
        check("R4 pop one cycle", {15'h0, rx_pop}, 16'h0000);

        // R5 transmit push
        wr(3'd0, 8'h9E);
        check("R5 push high", {15'h0, tx_push}, 16'h0001);
        check("R5 tx data", {8'h0, tx_data}, 16'h009E);
        @(negedge clk);
        check("R5 push one cycle", {15'h0, tx_push}, 16'h0000);

        // R10 unmapped addresses in the divisor bank
        wr(3'd3, 8'h80);
        for (int a = 2; a < 8; a++) begin
            if (a != 3) wr(a[2:0], 8'hFF);
        end
        check("R10 efr intact", {8'h0, efr}, 16'h0010);
        check("R10 xon/xoff intact", {xon1, xoff2}, 16'h1193);
        check("R10 ier/fcr intact", {ier, fcr}, 16'hA5C1);
        check("R10 mcr/lcr intact", {mcr, lcr}, 16'h3C80);
        rd(3'd6, r);
        check("R10 unmapped read", {8'h0, r}, 16'h0000);
        check("R10 no pop", {15'h0, rx_pop}, 16'h0000);

        // R7 data-port address in divisor bank raises no strobe
        rd(3'd0, r);
        check("R7 no pop in divisor bank", {15'h0, rx_pop}, 16'h0000);
        wr(3'd0, 8'h55);
        check("R7 no push in divisor bank", {15'h0, tx_push}, 16'h0000);
        check("R7 divisor low rewritten", divisor, 16'h1255);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule